// File: doc/BRIEF.md
# Event Frame Sequencing Stream Mux

This block merges several inbound 64-bit AXI4-Stream ports into a single outbound stream, grouped by event. Once every inbound port holds a frame, the block forwards one frame from each port, lowest port index first, so the frames of an event always leave in the same order. It forwards the payload of each frame unchanged. In front of each frame it sends one 64-bit header beat. The header carries what a receiver needs to rebuild the original sideband information. Nothing is appended after a frame.

A frame whose destination field equals a configured transition code is a transition frame. It is handled outside the event grouping and goes out alone with its own header. The outbound destination is derived from the port index in one of two ways. Indexed mode places the index at a chosen bit offset. Routed mode uses a per-port table that forces some destination bits and passes the rest through from the inbound destination. A one-stage register can be enabled on the inbound flow control and, separately, on the outbound flow control.

Top module: `evt_seq_mux`

## Requirements
- R1: While reset is high, and after reset until an inbound frame is available, `m_tvalid` is 0.
- R2: Every header beat has `m_tlast` 0 and carries the following constants. Bits 3:0 are 0x1. Bits 7:4 are 0x3 (log2 of 8 bytes). Bits 39:32 hold the number of inbound ports.
- R3: Header bits 23:16 hold the first user byte of the frame's first beat. Bits 31:24 hold the frame's inbound destination. Bits 47:40 hold the inbound port index.
- R4: An event starts only when every inbound port has a frame ready. Its frames leave in ascending port order. Each header carries its position in the event in bits 55:48 and the number of ports minus one in bits 63:56.
- R5: Each frame leaves as exactly one header beat followed by its data beats. The data and `tlast` of each data beat are unchanged, and no beat follows the frame's last beat before the next header.
- R6: Header bits 15:8 hold an event sequence number. It starts at 0 after reset and increments by one, modulo 256, after the last frame of each event. Transition frames leave it unchanged.
- R7: Between events, a frame at the head of any port whose destination equals `TRANS_DEST` is a transition frame. It takes precedence over starting an event, and among several the lowest port index goes first. It goes out alone, and its header has bits 55:48 and 63:56 both 0.
- R8: In indexed mode, `m_tdest` on the header and on every data beat of a frame equals the port index shifted left by `DEST_LSB`.
- R9: In routed mode, each `m_tdest` bit is taken from the value table where the port's mask bit is 1, and from the inbound destination where the mask bit is 0.
- R10: While `m_tvalid` is 1 and `m_tready` is 0, the outbound valid, data, last and destination stay unchanged in the next cycle.
- R11: Enabling the inbound or outbound pipeline registers changes neither the content nor the order of the outbound beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | NUM_SRC | Inbound valid, one per port |
| s_tready | output | NUM_SRC | Inbound ready, one per port |
| s_tdata | input | NUM_SRC*64 | Inbound data, port i at bits 64*i+63:64*i |
| s_tlast | input | NUM_SRC | Inbound end of frame |
| s_tdest | input | NUM_SRC*8 | Inbound destination, port i at bits 8*i+7:8*i |
| s_tuser | input | NUM_SRC*8 | Inbound first user byte, port i at bits 8*i+7:8*i |
| m_tvalid | output | 1 | Outbound valid |
| m_tready | input | 1 | Outbound ready |
| m_tdata | output | 64 | Outbound header or data |
| m_tlast | output | 1 | Outbound end of frame |
| m_tdest | output | 8 | Outbound destination |

## Verification
Two functions can meet in the same idle cycle: every port may hold a frame, so an event could start, while one or more of those heads is a transition frame. The bench provokes this by holding all ports back, loading a transition frame ahead of an ordinary event frame on a high-index port (and in a second case transition frames on two ports), and then releasing every port at once. The check is the order of the outbound stream. The transition frames must come first, lowest index first, each with zero position and total fields. The event must follow with the sequence number it would have had without the transition frames.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;

    localparam int DATA_W = 64;
    localparam int DEST_W = 8;
    localparam int USER_W = 8;

    localparam logic [3:0] HDR_VERSION = 4'h1;
    localparam logic [3:0] HDR_WIDTH   = 4'h3;

    // Packed header: first member lands in the top byte.
    typedef struct packed {
        logic [7:0] frame_total;
        logic [7:0] frame_pos;
        logic [7:0] src_index;
        logic [7:0] stream_count;
        logic [7:0] dest;
        logic [7:0] user;
        logic [7:0] seq;
        logic [3:0] width_code;
        logic [3:0] version;
    } evt_hdr_t;

    // One inbound beat as carried through the input stage.
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [USER_W-1:0] user;
        logic              last;
        logic [DATA_W-1:0] data;
    } in_beat_t;

    // One outbound beat as carried through the output stage.
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              last;
        logic [DATA_W-1:0] data;
    } out_beat_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;

    function automatic evt_hdr_t make_hdr(
        input logic [7:0] seq,
        input logic [7:0] user,
        input logic [7:0] dest,
        input logic [7:0] streams,
        input logic [7:0] index,
        input logic [7:0] pos,
        input logic [7:0] total
    );
        evt_hdr_t h;
        h.version      = HDR_VERSION;
        h.width_code   = HDR_WIDTH;
        h.seq          = seq;
        h.user         = user;
        h.dest         = dest;
        h.stream_count = streams;
        h.src_index    = index;
        h.frame_pos    = pos;
        h.frame_total  = total;
        return h;
    endfunction

    // Mask bit 1: take the forced value; mask bit 0: pass the source bit.
    function automatic logic [DEST_W-1:0] route_bits(
        input logic [DEST_W-1:0] mask,
        input logic [DEST_W-1:0] value,
        input logic [DEST_W-1:0] src
    );
        return (value & mask) | (src & ~mask);
    endfunction

endpackage

// File: rtl/evt_pipe_stage.sv
module evt_pipe_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    generate
        if (EN) begin : g_reg
            // Two-entry buffer so that in_ready comes straight from a flop.
            logic [W-1:0] mem [2];
            logic         wr_ptr;
            logic         rd_ptr;
            logic [1:0]   count;
            logic         push;
            logic         pop;

            assign in_ready  = (count != 2'd2);
            assign out_valid = (count != 2'd0);
            assign out_data  = mem[rd_ptr];
            assign push      = in_valid && in_ready;
            assign pop       = out_valid && out_ready;

            always_ff @(posedge clk) begin
                if (rst) begin
                    wr_ptr <= 1'b0;
                    rd_ptr <= 1'b0;
                    count  <= 2'd0;
                end else begin
                    if (push) begin
                        mem[wr_ptr] <= in_data;
                        wr_ptr      <= ~wr_ptr;
                    end
                    if (pop) begin
                        rd_ptr <= ~rd_ptr;
                    end
                    case ({push, pop})
                        2'b10:   count <= count + 2'd1;
                        2'b01:   count <= count - 2'd1;
                        default: count <= count;
                    endcase
                end
            end
        end else begin : g_wire
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end
    endgenerate

endmodule

// File: rtl/evt_dest_gen.sv
module evt_dest_gen
    import evt_seq_pkg::*;
#(
    parameter int                     NUM_SRC    = 2,
    parameter int                     IDX_W      = 1,
    parameter bit                     ROUTED     = 1'b0,
    parameter int                     DEST_LSB   = 0,
    parameter logic [NUM_SRC*8-1:0]   ROUTE_MASK = '0,
    parameter logic [NUM_SRC*8-1:0]   ROUTE_VAL  = '0
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DEST_W-1:0] src_dest,
    output logic [DEST_W-1:0] out_dest
);

    generate
        if (ROUTED) begin : g_routed
            logic [DEST_W-1:0] mask_sel;
            logic [DEST_W-1:0] val_sel;
            always_comb begin
                mask_sel = '0;
                val_sel  = '0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (idx == IDX_W'(i)) begin
                        mask_sel = ROUTE_MASK[i*DEST_W +: DEST_W];
                        val_sel  = ROUTE_VAL[i*DEST_W +: DEST_W];
                    end
                end
                out_dest = route_bits(mask_sel, val_sel, src_dest);
            end
        end else begin : g_indexed
            logic [DEST_W-1:0] idx_ext;
            assign idx_ext  = DEST_W'(idx);
            assign out_dest = idx_ext << DEST_LSB;
        end
    endgenerate

endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
    import evt_seq_pkg::*;
#(
    parameter int          NUM_SRC    = 2,
    parameter int          IDX_W      = 1,
    parameter logic [7:0]  TRANS_DEST = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       in_valid,
    output logic [NUM_SRC-1:0]       in_ready,
    input  in_beat_t                 in_beat [NUM_SRC],
    output logic                     o_valid,
    input  logic                     o_ready,
    output logic [DATA_W-1:0]        o_data,
    output logic                     o_last,
    output logic [IDX_W-1:0]         cur_idx,
    output logic [DEST_W-1:0]        cur_src_dest
);

    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NUM_SRC - 1);
    localparam logic [7:0]       STREAMS_B  = 8'(NUM_SRC);
    localparam logic [7:0]       TOTAL_M1_B = 8'(NUM_SRC - 1);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  cur_q;
    logic              trans_q;
    logic [7:0]        seq_q;

    logic [NUM_SRC-1:0] trans_vec;
    logic               trans_any;
    logic [IDX_W-1:0]   trans_idx;
    in_beat_t           head;
    evt_hdr_t           hdr;
    logic               data_fire_last;

    // Transition heads; the lowest index wins.
    always_comb begin
        trans_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            trans_vec[i] = in_valid[i] && (in_beat[i].dest == TRANS_DEST);
            if (trans_vec[i]) begin
                trans_idx = IDX_W'(i);
            end
        end
        trans_any = |trans_vec;
    end

    always_comb begin
        head = in_beat[0];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cur_q == IDX_W'(i)) begin
                head = in_beat[i];
            end
        end
    end

    assign hdr = make_hdr(seq_q, head.user, head.dest, STREAMS_B, 8'(cur_q),
                          trans_q ? 8'd0 : 8'(cur_q),
                          trans_q ? 8'd0 : TOTAL_M1_B);

    always_comb begin
        o_valid  = 1'b0;
        o_data   = head.data;
        o_last   = head.last;
        in_ready = '0;
        case (state_q)
            ST_HDR: begin
                o_valid = 1'b1;
                o_data  = hdr;
                o_last  = 1'b0;
            end
            ST_DATA: begin
                o_valid = in_valid[cur_q];
                for (int i = 0; i < NUM_SRC; i++) begin
                    in_ready[i] = (cur_q == IDX_W'(i)) && o_ready;
                end
            end
            default: begin
                o_valid = 1'b0;
            end
        endcase
    end

    assign data_fire_last = (state_q == ST_DATA) && in_valid[cur_q] && o_ready && head.last;
    assign cur_idx        = cur_q;
    assign cur_src_dest   = head.dest;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            trans_q <= 1'b0;
            seq_q   <= 8'd0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (trans_any) begin
                        cur_q   <= trans_idx;
                        trans_q <= 1'b1;
                        state_q <= ST_HDR;
                    end else if (&in_valid) begin
                        cur_q   <= '0;
                        trans_q <= 1'b0;
                        state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (o_ready) begin
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (data_fire_last) begin
                        if (trans_q) begin
                            state_q <= ST_IDLE;
                        end else if (cur_q == LAST_IDX) begin
                            seq_q   <= seq_q + 8'd1;
                            state_q <= ST_IDLE;
                        end else begin
                            cur_q   <= cur_q + IDX_W'(1);
                            state_q <= ST_HDR;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/evt_seq_mux.sv
module evt_seq_mux
    import evt_seq_pkg::*;
#(
    parameter int                   NUM_SRC    = 2,
    parameter bit                   ROUTED     = 1'b0,
    parameter int                   DEST_LSB   = 0,
    parameter logic [NUM_SRC*8-1:0] ROUTE_MASK = '0,
    parameter logic [NUM_SRC*8-1:0] ROUTE_VAL  = '0,
    parameter logic [7:0]           TRANS_DEST = 8'hFF,
    parameter bit                   IN_PIPE    = 1'b0,
    parameter bit                   OUT_PIPE   = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     s_tvalid,
    output logic [NUM_SRC-1:0]     s_tready,
    input  logic [NUM_SRC*64-1:0]  s_tdata,
    input  logic [NUM_SRC-1:0]     s_tlast,
    input  logic [NUM_SRC*8-1:0]   s_tdest,
    input  logic [NUM_SRC*8-1:0]   s_tuser,
    output logic                   m_tvalid,
    input  logic                   m_tready,
    output logic [63:0]            m_tdata,
    output logic                   m_tlast,
    output logic [7:0]             m_tdest
);

    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int IN_W   = $bits(in_beat_t);
    localparam int OUT_W  = $bits(out_beat_t);

    logic [NUM_SRC-1:0] core_valid;
    logic [NUM_SRC-1:0] core_ready;
    in_beat_t           core_beat [NUM_SRC];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_in
            in_beat_t  raw;
            logic [IN_W-1:0] piped;
            assign raw.data = s_tdata[gi*DATA_W +: DATA_W];
            assign raw.last = s_tlast[gi];
            assign raw.dest = s_tdest[gi*DEST_W +: DEST_W];
            assign raw.user = s_tuser[gi*USER_W +: USER_W];

            evt_pipe_stage #(.W(IN_W), .EN(IN_PIPE)) u_in_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (s_tvalid[gi]),
                .in_ready  (s_tready[gi]),
                .in_data   (raw),
                .out_valid (core_valid[gi]),
                .out_ready (core_ready[gi]),
                .out_data  (piped)
            );
            assign core_beat[gi] = in_beat_t'(piped);
        end
    endgenerate

    logic               ctrl_valid;
    logic               ctrl_ready;
    logic [DATA_W-1:0]  ctrl_data;
    logic               ctrl_last;
    logic [IDX_W-1:0]   ctrl_idx;
    logic [DEST_W-1:0]  ctrl_src_dest;
    logic [DEST_W-1:0]  ctrl_dest;

    evt_seq_ctrl #(
        .NUM_SRC    (NUM_SRC),
        .IDX_W      (IDX_W),
        .TRANS_DEST (TRANS_DEST)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (core_valid),
        .in_ready     (core_ready),
        .in_beat      (core_beat),
        .o_valid      (ctrl_valid),
        .o_ready      (ctrl_ready),
        .o_data       (ctrl_data),
        .o_last       (ctrl_last),
        .cur_idx      (ctrl_idx),
        .cur_src_dest (ctrl_src_dest)
    );

    evt_dest_gen #(
        .NUM_SRC    (NUM_SRC),
        .IDX_W      (IDX_W),
        .ROUTED     (ROUTED),
        .DEST_LSB   (DEST_LSB),
        .ROUTE_MASK (ROUTE_MASK),
        .ROUTE_VAL  (ROUTE_VAL)
    ) u_dest (
        .idx      (ctrl_idx),
        .src_dest (ctrl_src_dest),
        .out_dest (ctrl_dest)
    );

    out_beat_t       ob_in;
    out_beat_t       ob_out;
    logic [OUT_W-1:0] ob_out_raw;

    assign ob_in.data = ctrl_data;
    assign ob_in.last = ctrl_last;
    assign ob_in.dest = ctrl_dest;

    evt_pipe_stage #(.W(OUT_W), .EN(OUT_PIPE)) u_out_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ctrl_valid),
        .in_ready  (ctrl_ready),
        .in_data   (ob_in),
        .out_valid (m_tvalid),
        .out_ready (m_tready),
        .out_data  (ob_out_raw)
    );

    assign ob_out  = out_beat_t'(ob_out_raw);
    assign m_tdata = ob_out.data;
    assign m_tlast = ob_out.last;
    assign m_tdest = ob_out.dest;

endmodule

// File: rtl/evt_seq_mux_chk.sv
module evt_seq_mux_chk #(
    parameter int         NUM_SRC    = 2,
    parameter logic [7:0] TRANS_DEST = 8'hFF
) (
    input logic               clk,
    input logic               rst,
    input logic               m_tvalid,
    input logic               m_tready,
    input logic [63:0]        m_tdata,
    input logic               m_tlast,
    input logic [7:0]         m_tdest,
    input logic [NUM_SRC-1:0] core_ready
);

    localparam logic [7:0] LAST_POS = 8'(NUM_SRC - 1);

    logic       expect_hdr;
    logic       in_trans;
    logic [7:0] ev_pos;
    logic [7:0] seq_exp;
    logic       hdr_beat;
    logic       trans_hdr;
    logic       fire;

    assign fire      = m_tvalid && m_tready;
    assign hdr_beat  = m_tvalid && expect_hdr;
    assign trans_hdr = hdr_beat && (ev_pos == 8'd0) && (m_tdata[31:24] == TRANS_DEST);

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_hdr <= 1'b1;
            in_trans   <= 1'b0;
            ev_pos     <= 8'd0;
            seq_exp    <= 8'd0;
        end else if (fire) begin
            if (expect_hdr) begin
                expect_hdr <= 1'b0;
                in_trans   <= trans_hdr;
            end else if (m_tlast) begin
                expect_hdr <= 1'b1;
                if (!in_trans) begin
                    if (ev_pos == LAST_POS) begin
                        ev_pos  <= 8'd0;
                        seq_exp <= seq_exp + 8'd1;
                    end else begin
                        ev_pos <= ev_pos + 8'd1;
                    end
                end
            end
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tdest)));

    p_hdr_const_r2: assert property (@(posedge clk) disable iff (rst)
        hdr_beat |-> (m_tdata[7:0] == 8'h31 && m_tdata[39:32] == 8'(NUM_SRC) && !m_tlast));

    p_event_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (hdr_beat && !trans_hdr) |-> (m_tdata[47:40] == ev_pos && m_tdata[55:48] == ev_pos
                                      && m_tdata[63:56] == LAST_POS));

    p_trans_alone_r7: assert property (@(posedge clk) disable iff (rst)
        trans_hdr |-> (m_tdata[63:48] == 16'd0));

    p_seq_step_r6: assert property (@(posedge clk) disable iff (rst)
        hdr_beat |-> (m_tdata[15:8] == seq_exp));

    p_one_source_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_ready));

endmodule

bind evt_seq_mux evt_seq_mux_chk #(
    .NUM_SRC    (NUM_SRC),
    .TRANS_DEST (TRANS_DEST)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_tvalid   (m_tvalid),
    .m_tready   (m_tready),
    .m_tdata    (m_tdata),
    .m_tlast    (m_tlast),
    .m_tdest    (m_tdest),
    .core_ready (core_ready)
);

// File: tb/tb_evt_seq_mux.sv
`timescale 1ns/1ps
module tb_evt_seq_mux;

    localparam int NS   = 3;
    localparam int DLSB = 2;

    typedef struct packed {
        logic [7:0]  dest;
        logic [7:0]  user;
        logic        last;
        logic [63:0] data;
    } sbeat_t;

    typedef struct {
        bit          is_hdr;
        bit          trans;
        logic [63:0] data;
        logic        last;
        logic [7:0]  dest;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // Main instance: indexed, both pipeline options on
    logic [NS-1:0]    s_tvalid = '0;
    logic [NS-1:0]    s_tready;
    logic [NS*64-1:0] s_tdata  = '0;
    logic [NS-1:0]    s_tlast  = '0;
    logic [NS*8-1:0]  s_tdest  = '0;
    logic [NS*8-1:0]  s_tuser  = '0;
    logic             m_tvalid;
    logic             m_tready = 1'b0;
    logic [63:0]      m_tdata;
    logic             m_tlast;
    logic [7:0]       m_tdest;

    evt_seq_mux #(
        .NUM_SRC (NS), .ROUTED (1'b0), .DEST_LSB (DLSB),
        .IN_PIPE (1'b1), .OUT_PIPE (1'b1)
    ) dut (
        .clk (clk), .rst (rst),
        .s_tvalid (s_tvalid), .s_tready (s_tready), .s_tdata (s_tdata),
        .s_tlast (s_tlast), .s_tdest (s_tdest), .s_tuser (s_tuser),
        .m_tvalid (m_tvalid), .m_tready (m_tready), .m_tdata (m_tdata),
        .m_tlast (m_tlast), .m_tdest (m_tdest)
    );

    // Routed instance, no pipeline registers
    logic [1:0]   r_s_tvalid = '0;
    logic [1:0]   r_s_tready;
    logic [127:0] r_s_tdata  = '0;
    logic [1:0]   r_s_tlast  = '0;
    logic [15:0]  r_s_tdest  = '0;
    logic [15:0]  r_s_tuser  = '0;
    logic         r_m_tvalid;
    logic [63:0]  r_m_tdata;
    logic         r_m_tlast;
    logic [7:0]   r_m_tdest;

    evt_seq_mux #(
        .NUM_SRC (2), .ROUTED (1'b1),
        .ROUTE_MASK ({8'hF0, 8'h0F}), .ROUTE_VAL ({8'hA0, 8'h05})
    ) dut_rt (
        .clk (clk), .rst (rst),
        .s_tvalid (r_s_tvalid), .s_tready (r_s_tready), .s_tdata (r_s_tdata),
        .s_tlast (r_s_tlast), .s_tdest (r_s_tdest), .s_tuser (r_s_tuser),
        .m_tvalid (r_m_tvalid), .m_tready (1'b1), .m_tdata (r_m_tdata),
        .m_tlast (r_m_tlast), .m_tdest (r_m_tdest)
    );

    int     n_vec  = 0;
    int     n_fail = 0;
    bit     done   = 1'b0;
    sbeat_t srcq [NS][$];
    exp_t   expq [$];
    bit     gate [NS];
    logic [7:0] seq_model = 8'd0;
    int     beats_out = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] hdr_word(input logic [7:0] seq, input logic [7:0] user,
            input logic [7:0] dest, input logic [7:0] idx, input logic [7:0] pos, input logic [7:0] tot);
        return {tot, pos, idx, 8'(NS), dest, user, seq, 4'h3, 4'h1};
    endfunction

    function automatic logic [7:0] idx_dest(input int idx);
        return 8'(idx) << DLSB;
    endfunction

    task automatic push_frame(input int s, input int nb, input logic [7:0] dest,
                              input logic [7:0] pos, input logic [7:0] tot, input bit trans);
        sbeat_t b;
        exp_t   e;
        logic [7:0] user = 8'($urandom);
        e.is_hdr = 1'b1; e.trans = trans; e.last = 1'b0; e.dest = idx_dest(s);
        e.data   = hdr_word(seq_model, user, dest, 8'(s), pos, tot);
        expq.push_back(e);
        for (int k = 0; k < nb; k++) begin
            b.dest = dest; b.user = (k == 0) ? user : 8'($urandom);
            b.last = (k == nb - 1); b.data = {$urandom, $urandom};
            srcq[s].push_back(b);
            e.is_hdr = 1'b0; e.trans = 1'b0; e.data = b.data; e.last = b.last;
            expq.push_back(e);
        end
    endtask

    task automatic add_event(input int maxb);
        for (int s = 0; s < NS; s++) begin
            push_frame(s, 1 + ($urandom % maxb), 8'($urandom % 255), 8'(s), 8'(NS - 1), 1'b0);
        end
        seq_model = seq_model + 8'd1;
    endtask

    task automatic add_trans(input int s, input int nb);
        push_frame(s, nb, 8'hFF, 8'd0, 8'd0, 1'b1);
    endtask

    task automatic drain();
        int t = 0;
        while (expq.size() != 0 && t < 40000) begin
            @(posedge clk);
            t++;
        end
        chk(expq.size() == 0, "R5 stream drained", 64'(expq.size()), 64'd0);
    endtask

    // Inbound drivers: a single process serves every port
    initial begin
        bit hs [NS];
        for (int s = 0; s < NS; s++) begin hs[s] = 1'b0; gate[s] = 1'b1; end
        forever begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                if (hs[s]) begin
                    void'(srcq[s].pop_front());
                    hs[s] = 1'b0;
                    s_tvalid[s] = 1'b0;
                end
                if (!s_tvalid[s] && gate[s] && srcq[s].size() > 0 && ($urandom % 4) != 0) begin
                    s_tvalid[s] = 1'b1;
                end
                if (s_tvalid[s]) begin
                    s_tdata[s*64 +: 64] = srcq[s][0].data;
                    s_tlast[s]          = srcq[s][0].last;
                    s_tdest[s*8 +: 8]   = srcq[s][0].dest;
                    s_tuser[s*8 +: 8]   = srcq[s][0].user;
                end
            end
            #4;
            for (int s = 0; s < NS; s++) hs[s] = s_tvalid[s] && s_tready[s];
        end
    end

    // Outbound monitor with random backpressure
    initial begin
        bit          stall = 1'b0;
        logic [63:0] pd;
        logic        pl;
        logic [7:0]  pdst;
        exp_t        e;
        forever begin
            @(negedge clk);
            m_tready = rst ? 1'b0 : (($urandom % 10) < 7);
            #4;
            if (rst) begin
                chk(m_tvalid == 1'b0, "R1 valid low in reset", 64'(m_tvalid), 64'd0);
            end else begin
                if (stall) begin
                    chk(m_tvalid && m_tdata == pd && m_tlast == pl && m_tdest == pdst,
                        "R10 held under backpressure", m_tdata, pd);
                end
                stall = m_tvalid && !m_tready;
                pd = m_tdata; pl = m_tlast; pdst = m_tdest;
                if (m_tvalid && m_tready) begin
                    beats_out++;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R5 unexpected extra beat", m_tdata, 64'd0);
                    end else begin
                        e = expq.pop_front();
                        chk(m_tdest == e.dest, "R8 indexed destination", 64'(m_tdest), 64'(e.dest));
                        if (e.is_hdr) begin
                            chk(m_tdata[7:0] == e.data[7:0] && m_tdata[39:32] == e.data[39:32] && !m_tlast,
                                "R2 header constants", m_tdata, e.data);
                            chk(m_tdata[47:16] == e.data[47:16], "R3 header metadata", m_tdata, e.data);
                            chk(m_tdata[15:8] == e.data[15:8], "R6 sequence number", m_tdata, e.data);
                            if (e.trans)
                                chk(m_tdata[63:48] == e.data[63:48], "R7 transition fields", m_tdata, e.data);
                            else
                                chk(m_tdata[63:48] == e.data[63:48], "R4 event position", m_tdata, e.data);
                        end else begin
                            chk(m_tdata == e.data && m_tlast == e.last, "R5 data beat", m_tdata, e.data);
                        end
                    end
                end
            end
        end
    end

    // Routed instance capture
    logic [71:0] rt_cap [$];
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (!rst && r_m_tvalid) rt_cap.push_back({r_m_tdest, r_m_tdata});
        end
    end

    task automatic rt_drive(input logic [1:0] v, input logic [15:0] dest);
        logic [1:0] pend;
        @(negedge clk);
        r_s_tvalid = v; r_s_tdest = dest; r_s_tlast = 2'b11;
        r_s_tdata  = {64'h1111_0000_0000_0001, 64'h2222_0000_0000_0002};
        r_s_tuser  = 16'h5A3C;
        pend = v;
        for (int c = 0; c < 20 && pend != 0; c++) begin
            #4;
            pend = pend & ~r_s_tready;
            @(negedge clk);
            r_s_tvalid = pend;
        end
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R5 watchdog expired", 64'd0, 64'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        chk(m_tvalid == 1'b0, "R1 idle after reset", 64'(m_tvalid), 64'd0);

        // R4: one port withheld, no event may start
        gate[NS-1] = 1'b0;
        add_event(3);
        repeat (40) @(posedge clk);
        chk(beats_out == 0, "R4 no start without all ports", 64'(beats_out), 64'd0);
        gate[NS-1] = 1'b1;
        drain();

        // Random events, enough to wrap the sequence number (R6)
        for (int ev = 0; ev < 300; ev++) begin
            add_event(4);
            if ((ev % 20) == 19) drain();
        end
        drain();

        // R7: lone transition frame
        add_trans(1, 2);
        drain();

        // R7 collision: transition ahead of an event on the same cycle
        for (int s = 0; s < NS; s++) gate[s] = 1'b0;
        add_trans(NS-1, 3);
        add_event(2);
        repeat (5) @(negedge clk);
        for (int s = 0; s < NS; s++) gate[s] = 1'b1;
        drain();

        // R7 two transitions pending: lowest index first
        for (int s = 0; s < NS; s++) gate[s] = 1'b0;
        add_trans(0, 1);
        add_trans(2, 1);
        add_event(2);
        repeat (5) @(negedge clk);
        for (int s = 0; s < NS; s++) gate[s] = 1'b1;
        drain();
        chk(seq_model == 8'(303 % 256), "R6 model wrap count", 64'(seq_model), 64'(303 % 256));
        chk(expq.size() == 0 && beats_out > 0, "R11 piped stream complete", 64'(expq.size()), 64'd0);

        // Routed instance: event then transition (R9, R7)
        rt_cap.delete();
        rt_drive(2'b11, {8'h34, 8'h12});
        chk(rt_cap.size() == 4, "R9 routed beat count", 64'(rt_cap.size()), 64'd4);
        if (rt_cap.size() == 4) begin
            chk(rt_cap[0][71:64] == 8'h15 && rt_cap[1][71:64] == 8'h15, "R9 routed port 0",
                64'(rt_cap[0][71:64]), 64'h15);
            chk(rt_cap[2][71:64] == 8'hA4 && rt_cap[3][71:64] == 8'hA4, "R9 routed port 1",
                64'(rt_cap[2][71:64]), 64'hA4);
            chk(rt_cap[1][63:0] == 64'h2222_0000_0000_0002, "R11 unpiped data", rt_cap[1][63:0],
                64'h2222_0000_0000_0002);
        end
        rt_cap.delete();
        rt_drive(2'b10, {8'hFF, 8'h00});
        chk(rt_cap.size() == 2, "R7 routed transition beats", 64'(rt_cap.size()), 64'd2);
        if (rt_cap.size() == 2) begin
            chk(rt_cap[0][71:64] == 8'hAF, "R9 routed forced and passed bits", 64'(rt_cap[0][71:64]), 64'hAF);
            chk(rt_cap[0][63:48] == 16'd0 && rt_cap[0][47:40] == 8'd1, "R7 routed transition header",
                rt_cap[0][63:0], 64'd0);
            chk(rt_cap[0][15:8] == 8'd1, "R6 transition keeps sequence", 64'(rt_cap[0][15:8]), 64'd1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule